// File: doc/BRIEF.md
# Infrared pulse-width capture controller

This block measures the raw timing of an infrared remote-control burst. A demodulated receiver output (active low, idle high) is brought in through a two-flop synchronizer, cleaned by a de-glitch filter and sampled on a programmable tick. Each mark (receiver active) and each gap (receiver idle) is counted in ticks and stored as one byte. Marks and gaps alternate, and the first stored duration is always a mark.

The bytes fill a fixed 68-entry buffer that software reads as seventeen 32-bit words. A gap that runs longer than a programmable end count closes the message. That gap is stored as zero, every later byte stays zero, and an interrupt is raised. Capture then freezes until software writes a restart. Software reads the captured durations and decodes them into a scancode.

Top module: `irw_capture_top`

## Requirements
- R1: After reset every capture word reads 0, the interrupt output is low and the pending bit (bit 0 of word address 20) reads 0.
- R2: Durations are counted in sample ticks with the input idle high. Marks and gaps alternate, starting with a mark. Duration k is stored in capture word k/4 (word addresses 0 to 16), bits 8*(k%4)+7 down to 8*(k%4).
- R3: A duration of more than 255 ticks is stored as 255.
- R4: A gap of more than E ticks is stored as 0 and ends the message. E is the end count in bits 22:16 of the config word (address 17). All later bytes stay 0. A gap of exactly E ticks is stored normally.
- R5: Only the first 68 durations are stored and later ones are dropped. A closing gap still ends the message after an overflow.
- R6: When a message ends, the pending bit is set. The interrupt output equals pending AND the enable (bit 0 of address 19). Writing 1 to bit 0 of address 20 clears pending.
- R7: After a message ends, further input edges change no capture byte until a restart.
- R8: Writing 1 to bit 0 of address 18 clears all capture bytes and returns capture to waiting for a first mark.
- R9: The filtered input takes a new level only after the raw input has held it on D consecutive ticks. D is taken from bits 19:16 of address 21, and a value of 0 acts as 1. A shorter glitch leaves the running duration unbroken.
- R10: A tick occurs every P+1 clocks, where P is bits 15:0 of address 21. Capture runs only while config bit 0 (receiver enable) and bit 13 (measure enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ir_rx_n | input | 1 | Demodulated receiver output, active low |
| irq | output | 1 | Message-complete interrupt |

## Verification
The bench sends a message that mixes one-tick marks, gaps just under the end count and marks of exactly 255, 256 and 300 ticks. A counter that is off by one, or one that wraps instead of saturating, shows up as a wrong byte. An 80-duration burst checks that the last stored byte is the 68th and that the closing gap still raises the interrupt. A buffer with no bound would corrupt the count or never complete. The bench also sends edges after completion, a one-tick glitch inside a mark under a de-glitch depth of 3, a gap of exactly the end count, and a slower tick. These catch a design that keeps capturing after completion, that splits a mark at a glitch, that ends the message one tick early, or that ignores the tick period.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int unsigned ADDR_W      = 5;
    localparam int unsigned BYTES_PER_W = 4;
    localparam logic [ADDR_W-1:0] A_CONFIG  = 5'd17;
    localparam logic [ADDR_W-1:0] A_RESTART = 5'd18;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 5'd19;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR = 5'd20;
    localparam logic [ADDR_W-1:0] A_TIMING  = 5'd21;
    localparam int unsigned CFG_RX_BIT   = 0;
    localparam int unsigned CFG_MEAS_BIT = 13;
    localparam int unsigned CFG_END_LSB  = 16;
    localparam int unsigned TIM_DG_LSB   = 16;
endpackage

// File: rtl/irw_tick.sv
module irw_tick #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = period;
        end else if (cnt_q == '0) begin
            tick  = 1'b1;
            cnt_d = period;
        end else begin
            cnt_d = cnt_q - PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: with a nonzero period, two ticks never fall on adjacent clocks
    a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period != '0) |=> !tick);
endmodule

// File: rtl/irw_filter.sv
module irw_filter #(
    parameter int unsigned DG_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [DG_W-1:0] depth,
    input  logic            rx_raw,
    output logic            level
);
    typedef struct packed {
        logic            s1;
        logic            s2;
        logic            filt;
        logic [DG_W-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;
    logic [DG_W-1:0] need;

    always_comb begin
        need = (depth == '0) ? DG_W'(1) : depth;
        f_d    = f_q;
        f_d.s1 = rx_raw;
        f_d.s2 = f_q.s1;
        if (tick) begin
            if (f_q.s2 != f_q.filt) begin
                if (f_q.cnt + DG_W'(1) >= need) begin
                    f_d.filt = f_q.s2;
                    f_d.cnt  = '0;
                end else begin
                    f_d.cnt = f_q.cnt + DG_W'(1);
                end
            end else begin
                f_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        else        f_q <= f_d;
    end

    assign level = f_q.filt;

    // R9: the filtered level moves only on a sample tick
    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level));
endmodule

// File: rtl/irw_measure.sv
module irw_measure #(
    parameter int unsigned DEPTH = 68,
    parameter int unsigned END_W = 7,
    localparam int unsigned IDX_W = $clog2(DEPTH + 1),
    localparam int unsigned RUN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic               tick,
    input  logic               active,
    input  logic [END_W-1:0]   end_cnt,
    output logic [DEPTH*8-1:0] cap_flat,
    output logic               fin
);
    typedef struct packed {
        logic             started;
        logic             mark;
        logic [RUN_W-1:0] len;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ms_t;

    ms_t s_d, s_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic       wr;
    logic [7:0] wval;

    always_comb begin
        s_d  = s_q;
        mem_d = mem_q;
        fin  = 1'b0;
        wr   = 1'b0;
        wval = '0;
        if (clear) begin
            s_d = '0;
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (run && tick && !s_q.done) begin
            if (!s_q.started) begin
                if (active) begin
                    s_d.started = 1'b1;
                    s_d.mark    = 1'b1;
                    s_d.len     = RUN_W'(1);
                end
            end else if (active == s_q.mark) begin
                if (!s_q.mark && s_q.len >= RUN_W'(end_cnt)) begin
                    wr       = 1'b1;
                    wval     = '0;
                    s_d.done = 1'b1;
                    fin      = 1'b1;
                end else if (s_q.len != '1) begin
                    s_d.len = s_q.len + RUN_W'(1);
                end
            end else begin
                wr       = 1'b1;
                wval     = s_q.len;
                s_d.mark = ~s_q.mark;
                s_d.len  = RUN_W'(1);
                if (s_q.idx < IDX_W'(DEPTH)) s_d.idx = s_q.idx + IDX_W'(1);
            end
            if (wr && s_q.idx < IDX_W'(DEPTH)) mem_d[s_q.idx] = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign cap_flat[g*8 +: 8] = mem_q[g];
    end

    // R5: the write index never passes the end of the buffer
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= IDX_W'(DEPTH));
    // R7: a finished message stays frozen until cleared
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !clear) |=> (s_q.done && $stable(s_q.idx)));
    // R8: a restart returns capture to the empty waiting state
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!s_q.done && !s_q.started && s_q.idx == '0));
endmodule

// File: rtl/irw_capture_top.sv
module irw_capture_top
    import irw_pkg::*;
#(
    parameter int unsigned CAP_WORDS = 17,
    parameter int unsigned PER_W     = 16,
    parameter int unsigned DG_W      = 4,
    parameter int unsigned END_W     = 7,
    localparam int unsigned DEPTH    = CAP_WORDS * BYTES_PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ir_rx_n,
    output logic              irq
);
    typedef struct packed {
        logic             rx_en;
        logic             meas_en;
        logic [END_W-1:0] end_cnt;
        logic             irq_en;
        logic             pend;
        logic [PER_W-1:0] per;
        logic [DG_W-1:0]  dg;
    } ctl_t;

    ctl_t c_d, c_q;
    logic tick, level, fin, restart;
    logic [DEPTH*8-1:0] cap_flat;
    logic [31:0] cap_word [CAP_WORDS];

    assign restart = reg_wr && reg_addr == A_RESTART && reg_wdata[0];

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            case (reg_addr)
                A_CONFIG: begin
                    c_d.rx_en   = reg_wdata[CFG_RX_BIT];
                    c_d.meas_en = reg_wdata[CFG_MEAS_BIT];
                    c_d.end_cnt = reg_wdata[CFG_END_LSB +: END_W];
                end
                A_IRQ_EN:  c_d.irq_en = reg_wdata[0];
                A_IRQ_CLR: if (reg_wdata[0]) c_d.pend = 1'b0;
                A_TIMING: begin
                    c_d.per = reg_wdata[PER_W-1:0];
                    c_d.dg  = reg_wdata[TIM_DG_LSB +: DG_W];
                end
                default: ;
            endcase
        end
        if (fin) c_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{rx_en: 1'b0, meas_en: 1'b0, end_cnt: '0, irq_en: 1'b0,
                             pend: 1'b0, per: '0, dg: DG_W'(1)};
        else        c_q <= c_d;
    end

    irw_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(c_q.rx_en), .period(c_q.per), .tick(tick)
    );

    irw_filter #(.DG_W(DG_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .depth(c_q.dg),
        .rx_raw(ir_rx_n), .level(level)
    );

    irw_measure #(.DEPTH(DEPTH), .END_W(END_W)) u_measure (
        .clk(clk), .rst_n(rst_n), .clear(restart),
        .run(c_q.rx_en && c_q.meas_en), .tick(tick), .active(!level),
        .end_cnt(c_q.end_cnt), .cap_flat(cap_flat), .fin(fin)
    );

    for (genvar w = 0; w < CAP_WORDS; w++) begin : g_word
        assign cap_word[w] = cap_flat[w*32 +: 32];
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < CAP_WORDS) begin
            reg_rdata = cap_word[reg_addr];
        end else begin
            case (reg_addr)
                A_CONFIG: begin
                    reg_rdata[CFG_RX_BIT]            = c_q.rx_en;
                    reg_rdata[CFG_MEAS_BIT]          = c_q.meas_en;
                    reg_rdata[CFG_END_LSB +: END_W]  = c_q.end_cnt;
                end
                A_IRQ_EN:  reg_rdata[0] = c_q.irq_en;
                A_IRQ_CLR: reg_rdata[0] = c_q.pend;
                A_TIMING: begin
                    reg_rdata[PER_W-1:0]            = c_q.per;
                    reg_rdata[TIM_DG_LSB +: DG_W]   = c_q.dg;
                end
                default: ;
            endcase
        end
    end

    assign irq = c_q.pend && c_q.irq_en;

    // R6: the end of a message always leaves the pending bit set
    a_r6_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> c_q.pend);
    // R6: pending only appears through a completion
    a_r6_pending_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.pend) |-> $past(fin));
endmodule

// File: tb/tb_irw_capture_top.sv
module tb_irw_capture_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ir_rx_n = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int tp = 4;

    irw_capture_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ir_rx_n(ir_rx_n), .irq(irq)
    );

    always #10 clk = ~clk;

    // mark, gap pairs in ticks; the message closes with a mark of 6 and a long gap
    localparam int unsigned NV = 7;
    localparam int unsigned VEC [NV][2] = '{
        '{9, 4}, '{3, 3}, '{12, 7}, '{300, 5}, '{1, 2}, '{255, 19}, '{256, 1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic hold(input logic lvl, input int ticks);
        ir_rx_n = lvl;
        repeat (ticks * tp) @(negedge clk);
    endtask

    function automatic logic [7:0] sat(input int unsigned v);
        return (v > 255) ? 8'd255 : 8'(v);
    endfunction

    initial begin
        logic [31:0] r;
        logic [7:0] exp_b [68];
        for (int i = 0; i < 68; i++) exp_b[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, r);  chk("R1 word0", r, 32'h0);
        rd(5'd16, r); chk("R1 word16", r, 32'h0);
        rd(5'd20, r); chk("R1 pending", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // setup: tick every 4 clocks, de-glitch 1, end count 20
        wr(5'd21, (32'd1 << 16) | 32'd3);
        wr(5'd17, (32'd20 << 16) | (32'd1 << 13) | 32'd1);
        wr(5'd19, 32'd1);
        wr(5'd18, 32'd1);
        hold(1'b1, 5);

        // R2 R3 R4: table-driven message
        for (int v = 0; v < NV; v++) begin
            exp_b[2*v]   = sat(VEC[v][0]);
            exp_b[2*v+1] = sat(VEC[v][1]);
            hold(1'b0, int'(VEC[v][0]));
            hold(1'b1, int'(VEC[v][1]));
        end
        exp_b[14] = 8'd6;
        hold(1'b0, 6);
        hold(1'b1, 40);
        for (int w = 0; w < 17; w++) begin
            rd(5'(w), r);
            chk($sformatf("R2 R3 R4 word%0d", w), r,
                {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});
        end
        chk("R6 irq after end", {31'b0, irq}, 32'h1);
        rd(5'd20, r); chk("R6 pending", r, 32'h1);

        // R7: edges after completion are ignored
        hold(1'b0, 10); hold(1'b1, 10);
        rd(5'd0, r); chk("R7 word0 frozen", r, {exp_b[3], exp_b[2], exp_b[1], exp_b[0]});
        rd(5'd4, r); chk("R7 word4 frozen", r, 32'h0);

        // R6: interrupt clear
        wr(5'd20, 32'd1);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);

        // R8: restart clears the buffer
        wr(5'd18, 32'd1);
        rd(5'd0, r); chk("R8 word0 cleared", r, 32'h0);
        rd(5'd3, r); chk("R8 word3 cleared", r, 32'h0);

        // R5: overflow with 80 durations
        hold(1'b1, 3);
        for (int k = 0; k < 40; k++) begin
            hold(1'b0, 2);
            hold(1'b1, 3);
        end
        hold(1'b1, 40);
        rd(5'd16, r); chk("R5 last word", r, 32'h03020302);
        rd(5'd0, r);  chk("R5 first word", r, 32'h03020302);
        chk("R5 irq after overflow", {31'b0, irq}, 32'h1);
        wr(5'd20, 32'd1);

        // R9: de-glitch depth 3 swallows a one-tick glitch
        wr(5'd21, (32'd3 << 16) | 32'd3);
        wr(5'd18, 32'd1);
        hold(1'b1, 5);
        hold(1'b0, 5); hold(1'b1, 1); hold(1'b0, 4);
        hold(1'b1, 6); hold(1'b0, 3); hold(1'b1, 40);
        rd(5'd0, r); chk("R9 glitch filtered", r, 32'h0003060A);
        rd(5'd1, r); chk("R9 word1", r, 32'h0);
        wr(5'd20, 32'd1);

        // R10: measure disabled captures nothing
        wr(5'd21, (32'd1 << 16) | 32'd3);
        wr(5'd17, (32'd20 << 16) | 32'd1);
        wr(5'd18, 32'd1);
        hold(1'b0, 5); hold(1'b1, 30);
        rd(5'd0, r); chk("R10 measure off", r, 32'h0);
        chk("R10 no irq", {31'b0, irq}, 32'h0);

        // R10 R4: tick every 8 clocks, end count 5, gap of exactly 5 kept
        wr(5'd21, (32'd1 << 16) | 32'd7);
        wr(5'd17, (32'd5 << 16) | (32'd1 << 13) | 32'd1);
        wr(5'd18, 32'd1);
        tp = 8;
        hold(1'b1, 3);
        hold(1'b0, 5); hold(1'b1, 5); hold(1'b0, 2); hold(1'b1, 30);
        rd(5'd0, r); chk("R10 R4 slow tick and end count", r, 32'h00020505);
        chk("R6 irq again", {31'b0, irq}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule